// File: doc/BRIEF.md
# Subpage buffer ECC sequencer

This block sits between a host that moves 32-bit words and a byte-wide flash data stream. It buffers one subpage frame, made of 512 data bytes and a 16-byte spare area, and runs each transfer as one triggered whole-frame operation. The first 6 spare bytes are free for the host. The last 10 hold the check code.

To write, the host loads 128 data words through the word port, then one full word and one half word of free spare bytes, and pulses the encode trigger. The block then streams the 518 buffered bytes to flash, followed by 10 check bytes from a stub encoder, and raises controller-ready. To read, the host pulses the decode trigger. The block takes 528 bytes from flash into the buffer and compares the received check bytes with those the stub computes. It then raises controller-ready and reports the decode status. The host then reads 132 words: 128 data words and 4 spare words.

The stub stands in for the real code. Check byte k is the XOR of the 518 payload bytes, XORed with k. The decode status counts how many received check bytes differ from the recomputed ones.

Top module: `subpage_ecc_seq`

## Requirements
- R1: After reset, ctrl_ready is 1, fl_tx_valid and fl_rx_ready are 0, and dec_fail, dec_err and dec_fixed are 0. The buffer holds zeros, so host_rdata is 0.
- R2: In idle, an accepted host_wr stores host_wdata at the byte pointer in little-endian order (bits 7:0 go to the lowest address). It stores 4 bytes when host_half=0 and 2 bytes when host_half=1, then advances the pointer by that size. A write is ignored, and the pointer is left unchanged, if it would reach past byte 517.
- R3: After an accepted enc_go, the block offers buffer bytes 0 to 517 on fl_tx_data in order, then check bytes k=0 to 9, each equal to (XOR of bytes 0 to 517) ^ k. A byte moves when fl_tx_valid and fl_tx_ready are both 1. While it stalls, fl_tx_data holds its value.
- R4: An accepted trigger drops ctrl_ready in the next cycle. ctrl_ready rises in the cycle after the 528th byte transfer. While ctrl_ready is 1, there is no flash activity.
- R5: After an accepted dec_go, fl_rx_ready is 1 and each byte taken when fl_rx_valid=1 is stored at frame positions 0 to 527 in order.
- R6: In idle, host_rdata shows the 4 buffer bytes at the pointer, little-endian. An accepted host_rd advances the pointer by 4 for up to 132 words. Past that, host_rdata is 0 and host_rd has no effect.
- R7: After a decode, let n be the number of received check bytes that differ from the recomputed ones. If n=0, all status outputs are 0. If 1≤n≤4, dec_err=1 and dec_fixed=n-1. If n>4, dec_fail=1 and dec_fixed=0. An accepted dec_go clears the status, and an encode leaves it unchanged.
- R8: Every accepted trigger resets the host pointer to byte 0.
- R9: Only one operation runs at a time. While ctrl_ready=0, triggers, host_wr and host_rd are ignored, and host_rdata is 0. If enc_go and dec_go arrive together, the encode wins. In a cycle with a trigger, host accesses are ignored, and host_wr wins over host_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host word or half-word write strobe |
| host_half | input | 1 | 1: write only the low 16 bits |
| host_wdata | input | 32 | Host write data, little-endian |
| host_rd | input | 1 | Host read strobe, advances the pointer |
| host_rdata | output | 32 | Word at the host pointer |
| enc_go | input | 1 | Encode trigger |
| dec_go | input | 1 | Decode trigger |
| fl_tx_valid | output | 1 | Byte offered to flash |
| fl_tx_data | output | 8 | Byte to flash |
| fl_tx_ready | input | 1 | Flash takes the byte |
| fl_rx_valid | input | 1 | Byte offered by flash |
| fl_rx_data | input | 8 | Byte from flash |
| fl_rx_ready | output | 1 | Block takes the byte |
| ctrl_ready | output | 1 | No operation running |
| dec_fail | output | 1 | Too many mismatches to correct |
| dec_err | output | 1 | Correctable mismatches seen |
| dec_fixed | output | 2 | Mismatch count minus one |

## Verification
The bench uses the default parameters: 512 data bytes, 16 spare bytes, 10 check bytes and 4 correctable symbols. With these values the real limits are reachable: the 518-byte write limit, where a word is refused but a half word still fits, and the 528-byte read limit. The decode images are built with 0, 1, 4, 5 and 10 mismatching check bytes. That covers both edges of the correctable band and the all-mismatch case caused by a corrupted payload byte. Random stalls on both flash handshakes check that data holds during a stall and that byte order survives the gaps.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    localparam int unsigned SBX_DATA_BYTES  = 512;
    localparam int unsigned SBX_SPARE_BYTES = 16;
    localparam int unsigned SBX_CHECK_BYTES = 10;
    localparam int unsigned SBX_MAX_FIX     = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ENC  = 2'd1,
        SQ_DEC  = 2'd2
    } sq_mode_e;
endpackage

// File: rtl/sbx_frame_buf.sv
module sbx_frame_buf #(
    parameter int FRAME = 528,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [3:0]    wr_be,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_word
);
    logic [7:0] mem [FRAME];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FRAME; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (wr_be[k] && (int'(wr_addr) + k < FRAME))
                    mem[wr_addr + AW'(k)] <= wr_data[8*k +: 8];
            end
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = rd_addr + AW'(k);
        assign rd_word[8*k +: 8] = (int'(rd_addr) + k < FRAME) ? mem[ra] : 8'h00;
    end
endmodule

// File: rtl/sbx_ecc_stub.sv
module sbx_ecc_stub #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          feed,
    input  logic [7:0]    feed_byte,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    cmp_byte,
    output logic [7:0]    chk_byte,
    output logic          mismatch
);
    logic [7:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear)     acc_d = 8'h00;
        else if (feed) acc_d = acc_q ^ feed_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= 8'h00;
        else        acc_q <= acc_d;
    end

    assign chk_byte = acc_q ^ 8'(idx);
    assign mismatch = (cmp_byte != chk_byte);
endmodule

// File: rtl/sbx_seq.sv
module sbx_seq
    import sbx_pkg::*;
#(
    parameter int PAY   = 518,
    parameter int FRAME = 528,
    parameter int MAXE  = 4,
    parameter int PW    = 10,
    parameter int IW    = 4,
    parameter int MW    = 4,
    parameter int EW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_half,
    input  logic [31:0]   host_wdata,
    input  logic          host_rd,
    input  logic          enc_go,
    input  logic          dec_go,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic [7:0]    rd_byte,
    input  logic [7:0]    chk_byte,
    input  logic          mismatch,
    output logic          buf_we,
    output logic [PW-1:0] buf_waddr,
    output logic [3:0]    buf_be,
    output logic [31:0]   buf_wdata,
    output logic [PW-1:0] buf_raddr,
    output logic          host_en,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          rx_ready,
    output logic          acc_clear,
    output logic          acc_feed,
    output logic [7:0]    acc_byte,
    output logic [IW-1:0] chk_idx,
    output logic          ready,
    output logic          fail,
    output logic          err,
    output logic [EW-1:0] fix
);
    typedef struct packed {
        sq_mode_e      mode;
        logic [PW-1:0] cnt;
        logic [PW-1:0] ptr;
        logic [MW-1:0] mism;
        logic          ready;
        logic          fail;
        logic          err;
        logic [EW-1:0] fix;
    } st_t;

    st_t d, q;

    logic          idle, trig, hw_ok, hr_ok, in_pay, last, tx_fire, rx_fire;
    logic [2:0]    wsize;
    logic [MW-1:0] n_mis;

    always_comb begin
        idle    = (q.mode == SQ_IDLE);
        trig    = idle && (enc_go || dec_go);
        wsize   = host_half ? 3'd2 : 3'd4;
        hw_ok   = idle && !trig && host_wr && (int'(q.ptr) + int'(wsize) <= PAY);
        hr_ok   = idle && !trig && !host_wr && host_rd && (int'(q.ptr) + 4 <= FRAME);
        in_pay  = int'(q.cnt) < PAY;
        last    = int'(q.cnt) == FRAME - 1;
        tx_fire = (q.mode == SQ_ENC) && tx_ready;
        rx_fire = (q.mode == SQ_DEC) && rx_valid;
        n_mis   = q.mism + MW'(mismatch);

        buf_we    = hw_ok || rx_fire;
        buf_waddr = rx_fire ? q.cnt : q.ptr;
        buf_be    = rx_fire ? 4'b0001 : (host_half ? 4'b0011 : 4'b1111);
        buf_wdata = rx_fire ? {24'h0, rx_data} : host_wdata;
        buf_raddr = idle ? q.ptr : q.cnt;
        chk_idx   = IW'(q.cnt - PW'(PAY));
        acc_clear = trig;
        acc_feed  = (tx_fire || rx_fire) && in_pay;
        acc_byte  = rx_fire ? rx_data : rd_byte;

        d = q;
        unique case (q.mode)
            SQ_IDLE: begin
                if (enc_go) begin
                    d.mode  = SQ_ENC;
                    d.cnt   = '0;
                    d.ptr   = '0;
                    d.ready = 1'b0;
                end else if (dec_go) begin
                    d.mode  = SQ_DEC;
                    d.cnt   = '0;
                    d.ptr   = '0;
                    d.mism  = '0;
                    d.ready = 1'b0;
                    d.fail  = 1'b0;
                    d.err   = 1'b0;
                    d.fix   = '0;
                end else if (hw_ok) begin
                    d.ptr = q.ptr + PW'(wsize);
                end else if (hr_ok) begin
                    d.ptr = q.ptr + PW'(4);
                end
            end
            SQ_ENC: begin
                if (tx_ready) begin
                    if (last) begin
                        d.mode  = SQ_IDLE;
                        d.ready = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SQ_DEC: begin
                if (rx_valid) begin
                    if (last) begin
                        d.mode  = SQ_IDLE;
                        d.ready = 1'b1;
                        d.fail  = int'(n_mis) > MAXE;
                        d.err   = (n_mis != '0) && (int'(n_mis) <= MAXE);
                        d.fix   = ((n_mis != '0) && (int'(n_mis) <= MAXE))
                                  ? EW'(n_mis - 1'b1) : '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        if (!in_pay && mismatch) d.mism = n_mis;
                    end
                end
            end
            default: d.mode = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.mode  <= SQ_IDLE;
            q.ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign host_en  = (q.mode == SQ_IDLE);
    assign tx_valid = (q.mode == SQ_ENC);
    assign rx_ready = (q.mode == SQ_DEC);
    assign tx_data  = (q.mode != SQ_ENC) ? 8'h00 : (in_pay ? rd_byte : chk_byte);
    assign ready    = q.ready;
    assign fail     = q.fail;
    assign err      = q.err;
    assign fix      = q.fix;
endmodule

// File: rtl/subpage_ecc_seq.sv
module subpage_ecc_seq
    import sbx_pkg::*;
#(
    parameter int DATA_BYTES  = SBX_DATA_BYTES,
    parameter int SPARE_BYTES = SBX_SPARE_BYTES,
    parameter int CHECK_BYTES = SBX_CHECK_BYTES,
    parameter int MAX_FIX     = SBX_MAX_FIX,
    localparam int FIX_W      = $clog2(MAX_FIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_half,
    input  logic [31:0]      host_wdata,
    input  logic             host_rd,
    output logic [31:0]      host_rdata,
    input  logic             enc_go,
    input  logic             dec_go,
    output logic             fl_tx_valid,
    output logic [7:0]       fl_tx_data,
    input  logic             fl_tx_ready,
    input  logic             fl_rx_valid,
    input  logic [7:0]       fl_rx_data,
    output logic             fl_rx_ready,
    output logic             ctrl_ready,
    output logic             dec_fail,
    output logic             dec_err,
    output logic [FIX_W-1:0] dec_fixed
);
    localparam int FRAME = DATA_BYTES + SPARE_BYTES;
    localparam int PAY   = FRAME - CHECK_BYTES;
    localparam int PW    = $clog2(FRAME + 1);
    localparam int IW    = $clog2(CHECK_BYTES);
    localparam int MW    = $clog2(CHECK_BYTES + 1);

    logic          buf_we, host_en, acc_clear, acc_feed, mismatch;
    logic [PW-1:0] buf_waddr, buf_raddr;
    logic [3:0]    buf_be;
    logic [31:0]   buf_wdata, rd_word;
    logic [7:0]    acc_byte, chk_byte;
    logic [IW-1:0] chk_idx;

    sbx_frame_buf #(.FRAME(FRAME), .AW(PW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_addr(buf_waddr),
        .wr_be(buf_be), .wr_data(buf_wdata), .rd_addr(buf_raddr), .rd_word(rd_word)
    );

    sbx_ecc_stub #(.IW(IW)) u_ecc (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear), .feed(acc_feed),
        .feed_byte(acc_byte), .idx(chk_idx), .cmp_byte(fl_rx_data),
        .chk_byte(chk_byte), .mismatch(mismatch)
    );

    sbx_seq #(
        .PAY(PAY), .FRAME(FRAME), .MAXE(MAX_FIX), .PW(PW),
        .IW(IW), .MW(MW), .EW(FIX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_half(host_half),
        .host_wdata(host_wdata), .host_rd(host_rd), .enc_go(enc_go), .dec_go(dec_go),
        .tx_ready(fl_tx_ready), .rx_valid(fl_rx_valid), .rx_data(fl_rx_data),
        .rd_byte(rd_word[7:0]), .chk_byte(chk_byte), .mismatch(mismatch),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_be(buf_be), .buf_wdata(buf_wdata),
        .buf_raddr(buf_raddr), .host_en(host_en), .tx_valid(fl_tx_valid),
        .tx_data(fl_tx_data), .rx_ready(fl_rx_ready), .acc_clear(acc_clear),
        .acc_feed(acc_feed), .acc_byte(acc_byte), .chk_idx(chk_idx),
        .ready(ctrl_ready), .fail(dec_fail), .err(dec_err), .fix(dec_fixed)
    );

    assign host_rdata = host_en ? rd_word : 32'h0;
endmodule

// File: rtl/sbx_seq_check.sv
module sbx_seq_check #(
    parameter int EW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enc_go,
    input logic          dec_go,
    input logic          fl_tx_valid,
    input logic          fl_tx_ready,
    input logic [7:0]    fl_tx_data,
    input logic          fl_rx_ready,
    input logic          ctrl_ready,
    input logic          dec_fail,
    input logic          dec_err,
    input logic [EW-1:0] dec_fixed
);
    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_tx_valid && !fl_tx_ready |=> fl_tx_valid && $stable(fl_tx_data));

    assert_one_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_tx_valid && fl_rx_ready));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ready |-> !fl_tx_valid && !fl_rx_ready);

    assert_go_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ready && (enc_go || dec_go) |=> !ctrl_ready);

    assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_fail && dec_err));

    assert_fixed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_err |-> dec_fixed == '0);

    assert_dec_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ready && dec_go && !enc_go |=> !dec_fail && !dec_err);
endmodule

bind subpage_ecc_seq sbx_seq_check #(.EW(FIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enc_go(enc_go), .dec_go(dec_go),
    .fl_tx_valid(fl_tx_valid), .fl_tx_ready(fl_tx_ready), .fl_tx_data(fl_tx_data),
    .fl_rx_ready(fl_rx_ready), .ctrl_ready(ctrl_ready), .dec_fail(dec_fail),
    .dec_err(dec_err), .dec_fixed(dec_fixed)
);

// File: tb/subpage_ecc_seq_test.sv
`timescale 1ns/1ps
module subpage_ecc_seq_test;
    localparam int FR = 528;
    localparam int PL = 518;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_half = 0, host_rd = 0, enc_go = 0, dec_go = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        fl_tx_valid, fl_rx_ready, ctrl_ready, dec_fail, dec_err;
    logic [7:0]  fl_tx_data;
    logic        fl_tx_ready = 1'b1, fl_rx_valid = 1'b0;
    logic [7:0]  fl_rx_data = 8'h00;
    logic [1:0]  dec_fixed;

    always #4 clk = ~clk;

    subpage_ecc_seq uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_half(host_half),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .enc_go(enc_go), .dec_go(dec_go), .fl_tx_valid(fl_tx_valid),
        .fl_tx_data(fl_tx_data), .fl_tx_ready(fl_tx_ready), .fl_rx_valid(fl_rx_valid),
        .fl_rx_data(fl_rx_data), .fl_rx_ready(fl_rx_ready), .ctrl_ready(ctrl_ready),
        .dec_fail(dec_fail), .dec_err(dec_err), .dec_fixed(dec_fixed)
    );

    // behavioural reference
    logic [7:0] mem [FR];
    logic [7:0] img [FR];
    int         m_mode = 0, m_cnt = 0, m_ptr = 0, m_mis = 0, src_idx = 0;
    logic [7:0] m_acc = 0;
    logic       m_rdy = 1, m_fail = 0, m_err = 0;
    logic [1:0] m_fix = 0;
    int         mtotal = 0, mbad = 0, total = 0, bad = 0;
    bit         stall = 0, src_on = 0;

    task automatic mchk(string tag, logic [31:0] act, logic [31:0] exp);
        mtotal++;
        if (act !== exp) begin
            mbad++;
            $display("FAIL %s at %0t: act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] m_word();
        logic [31:0] w;
        w = 0;
        if (m_mode == 0)
            for (int k = 0; k < 4; k++)
                if (m_ptr + k < FR) w[8*k +: 8] = mem[m_ptr + k];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_ptr = 0; m_acc = 0; m_mis = 0;
            m_rdy = 1; m_fail = 0; m_err = 0; m_fix = 0; src_idx = 0;
            for (int i = 0; i < FR; i++) mem[i] = 0;
        end else begin
            case (m_mode)
                0: begin
                    if (enc_go) begin
                        m_mode = 1; m_cnt = 0; m_ptr = 0; m_rdy = 0; m_acc = 0;
                    end else if (dec_go) begin
                        m_mode = 2; m_cnt = 0; m_ptr = 0; m_rdy = 0; m_acc = 0;
                        m_mis = 0; m_fail = 0; m_err = 0; m_fix = 0; src_idx = 0;
                    end else if (host_wr) begin
                        int sz;
                        sz = host_half ? 2 : 4;
                        if (m_ptr + sz <= PL) begin
                            for (int k = 0; k < sz; k++) mem[m_ptr + k] = host_wdata[8*k +: 8];
                            m_ptr += sz;
                        end
                    end else if (host_rd) begin
                        if (m_ptr + 4 <= FR) m_ptr += 4;
                    end
                end
                1: if (fl_tx_ready) begin
                    if (m_cnt < PL) m_acc ^= mem[m_cnt];
                    if (m_cnt == FR - 1) begin m_mode = 0; m_rdy = 1; end
                    else m_cnt++;
                end
                default: if (fl_rx_valid) begin
                    src_idx++;
                    mem[m_cnt] = fl_rx_data;
                    if (m_cnt < PL) m_acc ^= fl_rx_data;
                    else if (fl_rx_data != (m_acc ^ 8'(m_cnt - PL))) m_mis++;
                    if (m_cnt == FR - 1) begin
                        m_mode = 0; m_rdy = 1;
                        m_fail = m_mis > 4;
                        m_err  = m_mis >= 1 && m_mis <= 4;
                        m_fix  = m_err ? 2'(m_mis - 1) : 2'd0;
                    end else m_cnt++;
                end
            endcase
        end
        #1;
        mchk("R4 ctrl_ready", ctrl_ready, m_rdy);
        mchk("R3 tx_valid", fl_tx_valid, m_mode == 1);
        if (m_mode == 1)
            mchk("R3 tx_data", fl_tx_data, m_cnt < PL ? mem[m_cnt] : (m_acc ^ 8'(m_cnt - PL)));
        mchk("R5 rx_ready", fl_rx_ready, m_mode == 2);
        mchk("R6 host_rdata", host_rdata, m_word());
        mchk("R7 status", {dec_fail, dec_err, dec_fixed}, {m_fail, m_err, m_fix});
    end

    always @(negedge clk) begin
        fl_tx_ready = stall ? ($urandom % 3 != 0) : 1'b1;
        fl_rx_valid = src_on && ($urandom % 4 != 0);
        fl_rx_data  = (src_idx < FR) ? img[src_idx] : 8'h00;
    end

    function automatic logic [7:0] pat(int i, int s);
        return 8'((i * 13 + s * 29 + 5) & 8'hff);
    endfunction

    task automatic build_img(int seed, int nbad, bit data_bad);
        logic [7:0] x;
        x = 0;
        for (int i = 0; i < PL; i++) begin img[i] = pat(i, seed); x ^= img[i]; end
        for (int k = 0; k < FR - PL; k++) img[PL + k] = x ^ 8'(k);
        for (int k = 0; k < nbad; k++) img[PL + k] ^= 8'h5a;
        if (data_bad) img[10] ^= 8'h01;
    endtask

    task automatic pulse(bit e, bit dd);
        @(negedge clk); enc_go = e; dec_go = dd;
        @(negedge clk); enc_go = 0; dec_go = 0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (ctrl_ready) return;
        end
        chk("R4 ready timeout", ctrl_ready, 1);
    endtask

    task automatic hwrite(logic [31:0] dat, bit h);
        @(negedge clk); host_wr = 1; host_half = h; host_wdata = dat;
        @(negedge clk); host_wr = 0; host_half = 0;
    endtask

    task automatic hread();
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic decode(int seed, int nbad, bit data_bad, bit e, bit f, logic [1:0] x, string tag);
        build_img(seed, nbad, data_bad);
        src_on = 1;
        pulse(0, 1);
        chk("R4 ready low after decode trigger", ctrl_ready, 0);
        chk("R5 rx_ready up", fl_rx_ready, 1);
        wait_ready();
        src_on = 0;
        chk(tag, {dec_fail, dec_err, dec_fixed}, {f, e, x});
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ctrl_ready", ctrl_ready, 1);
        chk("R1 tx_valid", fl_tx_valid, 0);
        chk("R1 rx_ready", fl_rx_ready, 0);
        chk("R1 status", {dec_fail, dec_err, dec_fixed}, 0);
        chk("R1 rdata", host_rdata, 0);

        stall = 1;
        decode(1, 0, 0, 0, 0, 2'd0, "R7 clean decode");
        chk("R8 pointer at 0 after decode", host_rdata, {img[3], img[2], img[1], img[0]});
        for (int w = 0; w < 134; w++) hread();
        chk("R6 read past frame is zero", host_rdata, 0);

        @(negedge clk); enc_go = 1;
        @(negedge clk); enc_go = 0;
        repeat (5) @(negedge clk);
        dec_go = 1; host_wr = 1; host_wdata = 32'h12345678;
        @(negedge clk); dec_go = 0; host_wr = 0;
        chk("R9 trigger ignored while busy", fl_tx_valid, 1);
        chk("R9 rdata zero while busy", host_rdata, 0);
        wait_ready();
        chk("R8 pointer reset by encode", host_rdata, {img[3], img[2], img[1], img[0]});
        chk("R7 status held through encode", {dec_fail, dec_err}, 0);

        for (int w = 0; w < 128; w++)
            hwrite({pat(4*w+3, 7), pat(4*w+2, 7), pat(4*w+1, 7), pat(4*w, 7)}, 0);
        hwrite({pat(515, 7), pat(514, 7), pat(513, 7), pat(512, 7)}, 0);
        hwrite(32'hdeadbeef, 0);
        hwrite({16'h0, pat(517, 7), pat(516, 7)}, 1);
        hwrite(32'h0000a5a5, 1);
        chk("R2 writes past 518 ignored", host_rdata, {img[521], img[520], img[519], img[518]});
        pulse(1, 0);
        chk("R3 encode starts", fl_tx_valid, 1);
        wait_ready();

        stall = 0;
        decode(2, 1, 0, 1, 0, 2'd0, "R7 one mismatch");
        decode(3, 4, 0, 1, 0, 2'd3, "R7 four mismatches");
        decode(4, 5, 0, 0, 1, 2'd0, "R7 five mismatches fail");
        stall = 1;
        decode(5, 0, 1, 0, 1, 2'd0, "R7 payload corrupt fail");
        decode(6, 2, 0, 1, 0, 2'd1, "R7 two mismatches");

        pulse(1, 1);
        chk("R9 encode wins", fl_tx_valid, 1);
        chk("R9 no decode", fl_rx_ready, 0);
        wait_ready();
        chk("R7 status held after encode", {dec_fail, dec_err, dec_fixed}, {1'b0, 1'b1, 2'd1});
        repeat (4) @(negedge clk);
    endtask

    initial begin
        bit timeout;
        timeout = 0;
        fork
            run_all();
            begin repeat (150000) @(posedge clk); timeout = 1; end
        join_any
        disable fork;
        if (timeout) begin
            total++; bad++;
            $display("FAIL R4 watchdog expired: act=1 exp=0");
        end
        $display("test done: total=%0d bad=%0d", total + mtotal, bad + mbad);
        $finish;
    end
endmodule